// File: doc/BRIEF.md
# Multi-function 32-bit integer ALU with multiply

This block is a purely combinational arithmetic and logic unit for a 32-bit integer datapath. It takes two operands and a 4-bit operation code and produces one result word in the same cycle. It has no clock, no reset and no stored state. The operations are add and subtract, three bitwise logic functions, three shifts, a signed compare that yields 0 or 1, three multiply flavours and a pass-through of the second operand.

The integer operations share one adder: subtract and compare both use the inverted-B path. Shifts go through a logarithmic right-shifter, and a left shift reverses the bits before and after that shifter. All multiply codes share one 33x33 signed multiplier. The operands are sign-extended or zero-extended, depending on the code, so that one array serves both the signed and the unsigned high word.

No overflow is flagged. Sums, differences and products wrap modulo 2^32. The three unassigned codes return zero.

Top module: `int_alu`

## Requirements
- R1: Code 0 returns A+B and code 12 returns A-B, both modulo 2^32, with no overflow indication.
- R2: Code 4 returns A XOR B, code 6 returns A OR B, and code 7 returns A AND B.
- R3: Code 1 shifts A left, code 5 shifts A right filling with zeros, and code 13 shifts A right filling with A[31]. The shift distance is B[4:0], and B[31:5] has no effect.
- R4: Code 2 returns 1 when A is less than B as two's-complement values, and 0 otherwise. Bits 31..1 of the result are always zero.
- R5: Code 8 returns bits 31..0 of the product A*B.
- R6: Code 9 returns bits 63..32 of the product of A and B taken as signed values.
- R7: Code 11 returns bits 63..32 of the product of A and B taken as unsigned values.
- R8: Code 15 returns B unchanged.
- R9: Codes 3, 10 and 14 return zero.
- R10: The result depends only on the present inputs. It follows any input change within the same cycle, with no clock edge between the change and the new result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation code (see requirements) |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand; supplies the shift distance for shift codes |
| result | output | 32 | Operation result |

## Verification
The hardest cases to reach are the signed high word of the product when either operand sits at the most negative value, and the signed compare when the operand signs differ. Random operands almost never land on these. The stimulus therefore crosses a fixed set of extreme operands (0, 1, all ones, 0x7FFFFFFF, 0x80000000, and shift distances with upper B bits set) against every operation code, and then adds random operands. Each result is compared with a 64-bit behavioural model.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD       = 4'd0,
        OP_SHL       = 4'd1,
        OP_SLT       = 4'd2,
        OP_XOR       = 4'd4,
        OP_SHR       = 4'd5,
        OP_OR        = 4'd6,
        OP_AND       = 4'd7,
        OP_MUL_LO    = 4'd8,
        OP_MUL_HI_SS = 4'd9,
        OP_MUL_HI_UU = 4'd11,
        OP_SUB       = 4'd12,
        OP_SHRA      = 4'd13,
        OP_PASS_B    = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_LEFT      = 2'd0,
        SH_RIGHT_LOG = 2'd1,
        SH_RIGHT_ARI = 2'd2
    } shift_kind_e;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub_en,
    output logic [W-1:0] sum,
    output logic         lt_signed
);

    logic [W-1:0] b_eff;

    always_comb begin
        b_eff = sub_en ? ~b : b;
        sum   = a + b_eff + {{(W-1){1'b0}}, sub_en};
        // differing signs decide directly; equal signs use the difference sign
        lt_signed = (a[W-1] != b[W-1]) ? a[W-1] : sum[W-1];
    end

    // R1: the adder path inverts back through the opposite operation
    always_comb begin
        if (!$isunknown({a, b, sub_en})) begin
            if (!sub_en) p_add_inverse_r1: assert (sum - b == a);
            else         p_sub_inverse_r1: assert (sum + b == a);
            if (sub_en && a == b) p_slt_equal_r4: assert (!lt_signed);
        end
    end

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
    import alu_pkg::*;
#(
    parameter int W  = 32,
    parameter int AW = $clog2(W)
) (
    input  logic [W-1:0]  src,
    input  logic [AW-1:0] amt,
    input  shift_kind_e   kind,
    output logic [W-1:0]  res
);

    logic [W-1:0] rev_in;
    logic [W-1:0] rev_out;
    logic [W-1:0] stage [AW+1];
    logic         fill;
    logic         is_left;

    assign is_left = (kind == SH_LEFT);
    assign fill    = (kind == SH_RIGHT_ARI) & src[W-1];

    for (genvar j = 0; j < W; j++) begin : g_rev
        assign rev_in[j]  = src[W-1-j];
        assign rev_out[j] = stage[AW][W-1-j];
    end

    assign stage[0] = is_left ? rev_in : src;

    for (genvar i = 0; i < AW; i++) begin : g_stage
        localparam int S = 1 << i;
        assign stage[i+1] = amt[i] ? {{S{fill}}, stage[i][W-1:S]} : stage[i];
    end

    assign res = is_left ? rev_out : stage[AW];

    // R3: a zero distance leaves the operand untouched in every direction
    always_comb begin
        if (!$isunknown({src, amt}) && amt == '0)
            p_zero_shift_r3: assert (res == src);
    end

endmodule

// File: rtl/alu_multiplier.sv
module alu_multiplier #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         signed_hi,
    output logic [W-1:0] prod_lo,
    output logic [W-1:0] prod_hi
);

    localparam int PW = 2 * (W + 1);

    logic signed [W:0]    ext_a;
    logic signed [W:0]    ext_b;
    logic signed [PW-1:0] prod;

    always_comb begin
        ext_a   = {signed_hi & a[W-1], a};
        ext_b   = {signed_hi & b[W-1], b};
        prod    = PW'(ext_a) * PW'(ext_b);
        prod_lo = prod[W-1:0];
        prod_hi = prod[2*W-1:W];
    end

    // R5: multiplying by one returns the operand in the low word
    // R7: unsigned high word is zero when one operand is zero
    always_comb begin
        if (!$isunknown({a, b, signed_hi})) begin
            if (b == {{(W-1){1'b0}}, 1'b1}) p_mul_one_r5: assert (prod_lo == a);
            if (!signed_hi && a == '0)      p_mul_zero_r7: assert (prod_hi == '0);
        end
    end

endmodule

// File: rtl/int_alu.sv
module int_alu
    import alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SEL_W  = 4
) (
    input  logic [SEL_W-1:0]  op_sel,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic [DATA_W-1:0] result
);

    localparam int AMT_W = $clog2(DATA_W);

    alu_op_e           op;
    logic              sub_en;
    logic              signed_hi;
    shift_kind_e       sh_kind;
    logic [DATA_W-1:0] sum;
    logic              lt_signed;
    logic [DATA_W-1:0] sh_res;
    logic [DATA_W-1:0] prod_lo;
    logic [DATA_W-1:0] prod_hi;

    always_comb begin
        op        = alu_op_e'(op_sel);
        sub_en    = (op == OP_SUB) || (op == OP_SLT);
        signed_hi = (op == OP_MUL_HI_SS);
        unique case (op)
            OP_SHL:  sh_kind = SH_LEFT;
            OP_SHRA: sh_kind = SH_RIGHT_ARI;
            default: sh_kind = SH_RIGHT_LOG;
        endcase
    end

    alu_addsub #(.W(DATA_W)) u_addsub (
        .a         (opnd_a),
        .b         (opnd_b),
        .sub_en    (sub_en),
        .sum       (sum),
        .lt_signed (lt_signed)
    );

    alu_shifter #(.W(DATA_W), .AW(AMT_W)) u_shifter (
        .src  (opnd_a),
        .amt  (opnd_b[AMT_W-1:0]),
        .kind (sh_kind),
        .res  (sh_res)
    );

    alu_multiplier #(.W(DATA_W)) u_mult (
        .a         (opnd_a),
        .b         (opnd_b),
        .signed_hi (signed_hi),
        .prod_lo   (prod_lo),
        .prod_hi   (prod_hi)
    );

    always_comb begin
        unique case (op)
            OP_ADD, OP_SUB:             result = sum;
            OP_SLT:                     result = {{(DATA_W-1){1'b0}}, lt_signed};
            OP_XOR:                     result = opnd_a ^ opnd_b;
            OP_OR:                      result = opnd_a | opnd_b;
            OP_AND:                     result = opnd_a & opnd_b;
            OP_SHL, OP_SHR, OP_SHRA:    result = sh_res;
            OP_MUL_LO:                  result = prod_lo;
            OP_MUL_HI_SS, OP_MUL_HI_UU: result = prod_hi;
            OP_PASS_B:                  result = opnd_b;
            default:                    result = '0;
        endcase
    end

    always_comb begin
        if (!$isunknown({op_sel, opnd_a, opnd_b})) begin
            if (op_sel == 4'd2)
                p_slt_bool_r4: assert (result[DATA_W-1:1] == '0);
            if (op_sel == 4'd3 || op_sel == 4'd10 || op_sel == 4'd14)
                p_unused_zero_r9: assert (result == '0);
            if (op_sel == 4'd7)
                p_and_subset_r2: assert ((result & ~opnd_a) == '0);
            if (op_sel == 4'd6)
                p_or_superset_r2: assert ((result & opnd_b) == opnd_b);
        end
    end

endmodule

// File: tb/int_alu_tb.sv
module int_alu_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_sel = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [31:0] result;
    int          n_tests = 0;
    int          n_fail  = 0;
    bit          done    = 1'b0;

    always #10 clk = ~clk;

    int_alu u_dut (
        .op_sel (op_sel),
        .opnd_a (opnd_a),
        .opnd_b (opnd_b),
        .result (result)
    );

    function automatic logic [31:0] model(input logic [3:0] s, input logic [31:0] a, input logic [31:0] b);
        logic signed [63:0] sa = $signed({{32{a[31]}}, a});
        logic signed [63:0] sb = $signed({{32{b[31]}}, b});
        logic signed [63:0] sp = sa * sb;
        logic [63:0]        up = {32'b0, a} * {32'b0, b};
        case (s)
            4'd0:  return a + b;
            4'd12: return a - b;
            4'd4:  return a ^ b;
            4'd6:  return a | b;
            4'd7:  return a & b;
            4'd1:  return a << b[4:0];
            4'd5:  return a >> b[4:0];
            4'd13: return 32'($signed(a) >>> b[4:0]);
            4'd2:  return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            4'd8:  return up[31:0];
            4'd9:  return sp[63:32];
            4'd11: return up[63:32];
            4'd15: return b;
            default: return 32'd0;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] s);
        case (s)
            4'd0, 4'd12:        return "R1";
            4'd4, 4'd6, 4'd7:   return "R2";
            4'd1, 4'd5, 4'd13:  return "R3";
            4'd2:               return "R4";
            4'd8:               return "R5";
            4'd9:               return "R6";
            4'd11:              return "R7";
            4'd15:              return "R8";
            default:            return "R9";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] exp);
        n_tests++;
        if (result !== exp) begin
            n_fail++;
            $display("FAIL %s op=%0d a=%h b=%h actual=%h expected=%h",
                     req, op_sel, opnd_a, opnd_b, result, exp);
        end
    endtask

    // drive after the rising edge, compare at the falling edge
    task automatic run(input logic [3:0] s, input logic [31:0] a, input logic [31:0] b);
        @(posedge clk);
        #1;
        op_sel = s; opnd_a = a; opnd_b = b;
        @(negedge clk);
        check(req_of(s), model(s, a, b));
    endtask

    logic [31:0] corner [10] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
                                 32'h8000_0000, 32'h0000_001F, 32'hFFFF_FFE3,
                                 32'h0000_0020, 32'h1234_5678, 32'hFFFF_0000};
    logic [3:0]  codes [16] = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7,
                                4'd8, 4'd9, 4'd10, 4'd11, 4'd12, 4'd13, 4'd14, 4'd15};

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", 32'd0);                     // R1: zero operands add to zero
        rst_n = 1'b1;

        // R10: result follows an input change with no clock edge in between
        @(posedge clk); #2;
        op_sel = 4'd0; opnd_a = 32'd5; opnd_b = 32'd7;
        #2; check("R10", 32'd12);
        opnd_b = 32'd9;
        #2; check("R10", 32'd14);
        op_sel = 4'd15;
        #2; check("R10", 32'd9);

        // directed corners: R6 signed-high sign cases, R3 upper B bits ignored
        run(4'd9,  32'h8000_0000, 32'h8000_0000);
        run(4'd9,  32'h8000_0000, 32'hFFFF_FFFF);
        run(4'd11, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        run(4'd1,  32'h0000_0001, 32'hFFFF_FFE1);
        run(4'd2,  32'h8000_0000, 32'h7FFF_FFFF);
        run(4'd2,  32'h7FFF_FFFF, 32'h8000_0000);

        for (int c = 0; c < 16; c++)
            for (int i = 0; i < 10; i++)
                for (int j = 0; j < 10; j++)
                    run(codes[c], corner[i], corner[j]);

        for (int c = 0; c < 16; c++)
            for (int k = 0; k < 200; k++)
                run(codes[c], $urandom, $urandom);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule